// File: doc/BRIEF.md
# MOESI Cache-Line State Controller

This block tracks the coherence state of every line in one processor's cache in a snooping multicore system, and it processes one event per accepted transfer. An event names a line index and a kind: a local read or write from the processor, a snooped read, ownership request or update broadcast from another core, or an eviction. The block looks up the line's current state in a small internal state table. It computes the next state and the bus commands the event needs, writes the new state back, and presents a registered response. The commands are: fetch the line, request ownership, broadcast new data to other copies, supply data to a snooping core, refresh a local copy in place, or write the line back to memory.

The block implements the five-state protocol in which an Owned line may keep being written while other caches hold copies. The owner pushes each new value to those copies and does not invalidate them. Data arrays, tag lookup and bus arbitration sit outside the block. The caller reports on `ev_peer_copy` whether another cache signalled that it holds the line.

Events enter on a valid/ready pair, and responses leave on a second valid/ready pair through a one-entry output register. An event is accepted on a clock edge where `ev_valid` and `ev_ready` are both high. `ev_ready` is high whenever the output register is empty or is being drained in the same cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and no new event is taken.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `rsp_valid` is low with all command outputs low. State codes are Invalid=0, Shared=1, Exclusive=2, Owned=3 and Modified=4.
- R2: `ev_ready` equals (not `rsp_valid`) or `rsp_ready`. An accepted event yields `rsp_valid` on the next cycle. A response that is not taken stays valid and unchanged.
- R3: Local read (kind 0). On an Invalid line it asserts `cmd_bus_rd`, and the line becomes Exclusive if `ev_peer_copy` is low or Shared if it is high. On any other state it issues no command and leaves the state unchanged.
- R4: Local write (kind 1) to an Exclusive line moves it to Modified with no command. A local write to a Modified line leaves it Modified with no command.
- R5: Local write (kind 1) to a Shared line asserts `cmd_own_req` and `cmd_bcast` and moves it to Owned. A local write to an Owned line asserts only `cmd_bcast` and stays Owned. A local write to an Invalid line asserts `cmd_bus_rd`. It goes to Modified when `ev_peer_copy` is low. When `ev_peer_copy` is high it also asserts `cmd_own_req` and `cmd_bcast` and goes to Owned.
- R6: Snooped read (kind 2). It moves Modified to Owned with `cmd_supply`, keeps Owned with `cmd_supply`, moves Exclusive to Shared with no command, and leaves Shared and Invalid unchanged.
- R7: Snooped ownership request (kind 3). It moves Modified and Owned to Shared with `cmd_supply`, moves Exclusive to Shared with no command, and leaves Shared and Invalid unchanged.
- R8: Snooped update broadcast (kind 4). On a Shared line it asserts `cmd_refresh` and the state stays Shared. In every other state it issues nothing and changes nothing.
- R9: Eviction (kind 5). A Modified or Owned line asserts `cmd_wb` and becomes Invalid. An Exclusive or Shared line becomes Invalid with no command. An Invalid line stays Invalid. `cmd_wb` is never asserted for any other kind.
- R10: The `rsp_next` of an event becomes the `rsp_prev` of the next event on the same line. Events on other lines leave that line's state untouched.
- R11: Kinds 6 and 7 are no-ops: no command, and the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_kind | input | 3 | Event kind code (0..5 defined, 6..7 no-op) |
| ev_line | input | IDXW | Line index |
| ev_peer_copy | input | 1 | Another cache reports holding the line |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer can take it |
| rsp_kind | output | 3 | Kind of the event answered |
| rsp_line | output | IDXW | Line index of the event answered |
| rsp_prev | output | 3 | State before the event |
| rsp_next | output | 3 | State after the event |
| cmd_bus_rd | output | 1 | Fetch the line from shared memory |
| cmd_own_req | output | 1 | Request ownership on the bus |
| cmd_bcast | output | 1 | Broadcast new data to other copies |
| cmd_supply | output | 1 | Supply this cache's data to a snooping core |
| cmd_refresh | output | 1 | Overwrite the local copy with broadcast data |
| cmd_wb | output | 1 | Write the line back to shared memory |

## Verification
The bound checker watches the rules that hold on every cycle. These are response hold under back-pressure, the ready rule, commands appearing only with a valid response, write-back only on eviction of dirty lines, supply only from Modified or Owned lines, refresh only on Shared lines, and the silent Exclusive-to-Modified upgrade. The per-line history is beyond any single-cycle property. That history covers an update reaching a line only after an ownership hand-off, a state surviving traffic to other lines, and fill decisions that depend on `ev_peer_copy`. Only the bench's directed sequences and its random traffic, which run against a behavioural per-line model, show it.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    ST_INV = 3'd0,
    ST_SHR = 3'd1,
    ST_EXC = 3'd2,
    ST_OWN = 3'd3,
    ST_MOD = 3'd4
  } line_st_e;

  typedef enum logic [2:0] {
    EV_LOC_RD  = 3'd0,
    EV_LOC_WR  = 3'd1,
    EV_SNP_RD  = 3'd2,
    EV_SNP_OWN = 3'd3,
    EV_SNP_UPD = 3'd4,
    EV_EVICT   = 3'd5
  } ev_kind_e;

  typedef struct packed {
    logic bus_rd;
    logic own_req;
    logic bcast;
    logic supply;
    logic refresh;
    logic wb;
  } cmd_t;

  localparam int unsigned STW = 3;

  function automatic logic is_dirty(input line_st_e s);
    return (s == ST_MOD) || (s == ST_OWN);
  endfunction

endpackage

// File: rtl/moesi_state_table.sv
module moesi_state_table
  import moesi_pkg::*;
#(
  parameter int unsigned NLINES = 16,
  localparam int unsigned IDXW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] rd_idx,
  output line_st_e        rd_st,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  line_st_e        wr_st
);

  logic [NLINES-1:0][STW-1:0] st_all;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= ST_INV;
      end else if (wr_en && (wr_idx == IDXW'(g))) begin
        q <= wr_st;
      end
    end
    assign st_all[g] = q;
  end

  always_comb begin
    rd_st = ST_INV;
    for (int i = 0; i < NLINES; i++) begin
      if (rd_idx == IDXW'(i)) rd_st = line_st_e'(st_all[i]);
    end
  end

endmodule

// File: rtl/moesi_next_state.sv
module moesi_next_state
  import moesi_pkg::*;
(
  input  logic [2:0] kind,
  input  line_st_e   cur,
  input  logic       peer_copy,
  output line_st_e   nxt,
  output cmd_t       cmd
);

  always_comb begin
    nxt = cur;
    cmd = '0;
    case (kind)
      EV_LOC_RD: begin
        if (cur == ST_INV) begin
          cmd.bus_rd = 1'b1;
          nxt        = peer_copy ? ST_SHR : ST_EXC;
        end
      end
      EV_LOC_WR: begin
        case (cur)
          ST_INV: begin
            cmd.bus_rd = 1'b1;
            if (peer_copy) begin
              cmd.own_req = 1'b1;
              cmd.bcast   = 1'b1;
              nxt         = ST_OWN;
            end else begin
              nxt = ST_MOD;
            end
          end
          ST_SHR: begin
            cmd.own_req = 1'b1;
            cmd.bcast   = 1'b1;
            nxt         = ST_OWN;
          end
          ST_EXC:  nxt = ST_MOD;
          ST_OWN:  cmd.bcast = 1'b1;
          default: nxt = cur;
        endcase
      end
      EV_SNP_RD: begin
        case (cur)
          ST_MOD: begin
            cmd.supply = 1'b1;
            nxt        = ST_OWN;
          end
          ST_OWN:  cmd.supply = 1'b1;
          ST_EXC:  nxt = ST_SHR;
          default: nxt = cur;
        endcase
      end
      EV_SNP_OWN: begin
        if (is_dirty(cur)) begin
          cmd.supply = 1'b1;
          nxt        = ST_SHR;
        end else if (cur == ST_EXC) begin
          nxt = ST_SHR;
        end
      end
      EV_SNP_UPD: begin
        if (cur == ST_SHR) cmd.refresh = 1'b1;
      end
      EV_EVICT: begin
        cmd.wb = is_dirty(cur);
        nxt    = ST_INV;
      end
      default: begin
        nxt = cur;
      end
    endcase
  end

endmodule

// File: rtl/moesi_rsp_stage.sv
module moesi_rsp_stage
  import moesi_pkg::*;
#(
  parameter int unsigned IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_kind,
  input  logic [IDXW-1:0] in_line,
  input  line_st_e        in_prev,
  input  line_st_e        in_next,
  input  cmd_t            in_cmd,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2:0]      out_kind,
  output logic [IDXW-1:0] out_line,
  output line_st_e        out_prev,
  output line_st_e        out_next,
  output cmd_t            out_cmd
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_line  <= '0;
      out_prev  <= ST_INV;
      out_next  <= ST_INV;
      out_cmd   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_kind <= in_kind;
        out_line <= in_line;
        out_prev <= in_prev;
        out_next <= in_next;
        out_cmd  <= in_cmd;
      end
    end
  end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int unsigned NLINES = 16,
  localparam int unsigned IDXW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  output logic            ev_ready,
  input  logic [2:0]      ev_kind,
  input  logic [IDXW-1:0] ev_line,
  input  logic            ev_peer_copy,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [2:0]      rsp_kind,
  output logic [IDXW-1:0] rsp_line,
  output logic [2:0]      rsp_prev,
  output logic [2:0]      rsp_next,
  output logic            cmd_bus_rd,
  output logic            cmd_own_req,
  output logic            cmd_bcast,
  output logic            cmd_supply,
  output logic            cmd_refresh,
  output logic            cmd_wb
);

  line_st_e cur_st;
  line_st_e nxt_st;
  cmd_t     nxt_cmd;
  logic     accept;
  line_st_e q_prev;
  line_st_e q_next;
  cmd_t     q_cmd;

  assign accept = ev_valid && ev_ready;

  moesi_state_table #(.NLINES(NLINES)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (ev_line),
    .rd_st  (cur_st),
    .wr_en  (accept),
    .wr_idx (ev_line),
    .wr_st  (nxt_st)
  );

  moesi_next_state u_next (
    .kind      (ev_kind),
    .cur       (cur_st),
    .peer_copy (ev_peer_copy),
    .nxt       (nxt_st),
    .cmd       (nxt_cmd)
  );

  moesi_rsp_stage #(.IDXW(IDXW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (ev_valid),
    .in_ready  (ev_ready),
    .in_kind   (ev_kind),
    .in_line   (ev_line),
    .in_prev   (cur_st),
    .in_next   (nxt_st),
    .in_cmd    (nxt_cmd),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_kind  (rsp_kind),
    .out_line  (rsp_line),
    .out_prev  (q_prev),
    .out_next  (q_next),
    .out_cmd   (q_cmd)
  );

  assign rsp_prev    = q_prev;
  assign rsp_next    = q_next;
  assign cmd_bus_rd  = rsp_valid && q_cmd.bus_rd;
  assign cmd_own_req = rsp_valid && q_cmd.own_req;
  assign cmd_bcast   = rsp_valid && q_cmd.bcast;
  assign cmd_supply  = rsp_valid && q_cmd.supply;
  assign cmd_refresh = rsp_valid && q_cmd.refresh;
  assign cmd_wb      = rsp_valid && q_cmd.wb;

endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk #(
  parameter int unsigned IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_valid,
  input logic            ev_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [2:0]      rsp_kind,
  input logic [IDXW-1:0] rsp_line,
  input logic [2:0]      rsp_prev,
  input logic [2:0]      rsp_next,
  input logic            cmd_bus_rd,
  input logic            cmd_own_req,
  input logic            cmd_bcast,
  input logic            cmd_supply,
  input logic            cmd_refresh,
  input logic            cmd_wb
);

  logic any_cmd;
  assign any_cmd = cmd_bus_rd | cmd_own_req | cmd_bcast | cmd_supply | cmd_refresh | cmd_wb;

  // R2: stalled response blocks new events
  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !ev_ready);

  // R2: stalled response holds its content
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_line) && $stable(rsp_next)
                                   && $stable(rsp_prev) && $stable(rsp_kind)));

  // R2: accepted event produces a response next cycle
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> rsp_valid);

  // R1: commands only appear with a valid response
  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |-> rsp_valid);

  // R9: write-back only on eviction of a dirty line, ending Invalid
  assert_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wb |-> (rsp_kind == 3'd5 && (rsp_prev == 3'd4 || rsp_prev == 3'd3) && rsp_next == 3'd0));

  // R6 / R7: supply only from Modified or Owned on a snoop
  assert_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_supply |-> ((rsp_kind == 3'd2 || rsp_kind == 3'd3) && (rsp_prev == 3'd4 || rsp_prev == 3'd3)));

  // R8: refresh only on a Shared line that stays Shared
  assert_refresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refresh |-> (rsp_kind == 3'd4 && rsp_prev == 3'd1 && rsp_next == 3'd1));

  // R4: silent Exclusive to Modified upgrade
  assert_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 3'd1 && rsp_prev == 3'd2) |-> (rsp_next == 3'd4 && !any_cmd));

  // R10: reported states are legal codes
  assert_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_next <= 3'd4 && rsp_prev <= 3'd4));

endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_valid    (ev_valid),
  .ev_ready    (ev_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_kind    (rsp_kind),
  .rsp_line    (rsp_line),
  .rsp_prev    (rsp_prev),
  .rsp_next    (rsp_next),
  .cmd_bus_rd  (cmd_bus_rd),
  .cmd_own_req (cmd_own_req),
  .cmd_bcast   (cmd_bcast),
  .cmd_supply  (cmd_supply),
  .cmd_refresh (cmd_refresh),
  .cmd_wb      (cmd_wb)
);

// File: tb/tb_moesi_line_ctrl.sv
`timescale 1ns/1ps
module tb_moesi_line_ctrl;

  localparam int NL = 16;
  localparam int IW = 4;
  // state codes per R1: I=0 S=1 E=2 O=3 M=4
  localparam int I_ = 0, S_ = 1, E_ = 2, O_ = 3, M_ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic ev_ready;
  logic [2:0] ev_kind = '0;
  logic [IW-1:0] ev_line = '0;
  logic ev_peer_copy = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [2:0] rsp_kind;
  logic [IW-1:0] rsp_line;
  logic [2:0] rsp_prev, rsp_next;
  logic cmd_bus_rd, cmd_own_req, cmd_bcast, cmd_supply, cmd_refresh, cmd_wb;

  always #4 clk = ~clk;

  moesi_line_ctrl #(.NLINES(NL)) dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_line(ev_line), .ev_peer_copy(ev_peer_copy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_line(rsp_line), .rsp_prev(rsp_prev), .rsp_next(rsp_next),
    .cmd_bus_rd(cmd_bus_rd), .cmd_own_req(cmd_own_req), .cmd_bcast(cmd_bcast),
    .cmd_supply(cmd_supply), .cmd_refresh(cmd_refresh), .cmd_wb(cmd_wb)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  // behavioural model
  int  m_st[NL];
  bit  m_valid;
  int  m_kind, m_line, m_prev, m_next;
  bit [5:0] m_cmd;   // {bus_rd, own_req, bcast, supply, refresh, wb}

  function automatic string tag_of(input int k);
    case (k)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      default: return "R11";
    endcase
  endfunction

  // expected per-event result, written from the requirement text
  function automatic void expect_ev(input int k, input int s, input bit peer,
                                    output int nx, output bit [5:0] c);
    nx = s; c = 6'b0;
    if (k == 0 && s == I_) begin c = 6'b100000; nx = peer ? S_ : E_; end           // R3
    else if (k == 1) begin
      if (s == E_) nx = M_;                                                        // R4
      else if (s == S_) begin c = 6'b011000; nx = O_; end                          // R5
      else if (s == O_) c = 6'b001000;
      else if (s == I_) begin
        if (peer) begin c = 6'b111000; nx = O_; end else begin c = 6'b100000; nx = M_; end
      end
    end
    else if (k == 2) begin                                                         // R6
      if (s == M_) begin c = 6'b000100; nx = O_; end
      else if (s == O_) c = 6'b000100;
      else if (s == E_) nx = S_;
    end
    else if (k == 3) begin                                                         // R7
      if (s == M_ || s == O_) begin c = 6'b000100; nx = S_; end
      else if (s == E_) nx = S_;
    end
    else if (k == 4) begin                                                         // R8
      if (s == S_) c = 6'b000010;
    end
    else if (k == 5) begin                                                         // R9
      if (s == M_ || s == O_) c = 6'b000001;
      nx = I_;
    end
  endfunction

  task automatic compare(input string why);
    bit [5:0] got_c;
    bit ok;
    got_c = {cmd_bus_rd, cmd_own_req, cmd_bcast, cmd_supply, cmd_refresh, cmd_wb};
    ok = (rsp_valid == m_valid) && (got_c == (m_valid ? m_cmd : 6'b0));
    if (m_valid)
      ok = ok && (int'(rsp_kind) == m_kind) && (int'(rsp_line) == m_line) &&
           (int'(rsp_prev) == m_prev) && (int'(rsp_next) == m_next);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got v=%0b line=%0d prev=%0d next=%0d cmd=%b exp v=%0b line=%0d prev=%0d next=%0d cmd=%b",
               (why != "") ? why : (m_valid ? tag_of(m_kind) : "R2"),
               rsp_valid, rsp_line, rsp_prev, rsp_next, got_c,
               m_valid, m_line, m_prev, m_next, m_valid ? m_cmd : 6'b0);
    end
  endtask

  // one cycle: drive at negedge, check ready, advance model, compare next negedge
  task automatic step(input bit v, input int k, input int ln, input bit peer, input bit rdy);
    bit acc;
    ev_valid = v; ev_kind = 3'(k); ev_line = IW'(ln); ev_peer_copy = peer; rsp_ready = rdy;
    #1;
    n_cmp++;
    if (ev_ready !== (!m_valid || rdy)) begin   // R2 ready rule
      n_bad++;
      $display("FAIL R2: ev_ready=%0b exp %0b", ev_ready, (!m_valid || rdy));
    end
    acc = v && (!m_valid || rdy);
    if (acc) begin
      int nx; bit [5:0] c;
      expect_ev(k, m_st[ln], peer, nx, c);
      m_valid = 1; m_kind = k; m_line = ln; m_prev = m_st[ln]; m_next = nx; m_cmd = c;
      m_st[ln] = nx;                             // R10 persistence in the model
    end else if (rdy) begin
      m_valid = 0;
    end
    @(negedge clk);
    compare("");
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin : main
    foreach (m_st[i]) m_st[i] = I_;
    m_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");   // R1: idle after reset
    // R1: every line starts Invalid (evict reports prev=0)
    for (int i = 0; i < NL; i++) step(1, 5, i, 0, 1);
    step(0, 0, 0, 0, 1);

    // line 0 walk through all states
    step(1, 0, 0, 0, 1);   // R3 miss, no peer -> E
    step(1, 0, 0, 0, 1);   // R3 hit
    step(1, 1, 0, 0, 1);   // R4 E->M silent
    step(1, 1, 0, 0, 1);   // R4 M stays
    step(1, 2, 0, 0, 1);   // R6 M->O supply
    step(1, 1, 0, 0, 1);   // R5 O write broadcasts
    step(1, 4, 0, 0, 1);   // R8 update on O ignored
    step(1, 3, 0, 0, 1);   // R7 O->S supply
    step(1, 4, 0, 0, 1);   // R8 refresh on S
    step(1, 1, 0, 0, 1);   // R5 S->O
    step(1, 2, 0, 0, 1);   // R6 O keeps supplying
    step(1, 5, 0, 0, 1);   // R9 O evict wb
    // line 1: shared fill, clean evict
    step(1, 0, 1, 1, 1);   // R3 miss with peer -> S
    step(1, 2, 1, 0, 1);   // R6 S unchanged
    step(1, 3, 1, 0, 1);   // R7 S unchanged
    step(1, 5, 1, 0, 1);   // R9 clean evict
    // lines 2,3: write misses
    step(1, 1, 2, 0, 1);   // R5 I write no peer -> M
    step(1, 3, 2, 0, 1);   // R7 M->S supply
    step(1, 1, 3, 1, 1);   // R5 I write with peer -> O
    step(1, 5, 3, 0, 1);   // R9 wb
    step(1, 5, 3, 0, 1);   // R9 I stays
    // line 4: E paths
    step(1, 0, 4, 0, 1);
    step(1, 2, 4, 0, 1);   // R6 E->S
    step(1, 0, 5, 0, 1);
    step(1, 3, 5, 0, 1);   // R7 E->S
    step(1, 4, 6, 0, 1);   // R8 update on I ignored
    step(1, 6, 4, 1, 1);   // R11 no-op
    step(1, 7, 4, 1, 1);   // R11 no-op
    step(1, 0, 4, 0, 1);   // R10/R11 state still S
    // back-pressure R2
    step(1, 1, 7, 0, 0);
    step(1, 0, 7, 0, 0);
    step(1, 0, 7, 0, 0);
    step(1, 0, 7, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);

    // random traffic on a few lines to stress R10 history
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 5) != 0, int'($urandom % 8), int'($urandom % 4),
           bit'($urandom % 2), ($urandom % 4) != 0);
    end
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule